// File: doc/BRIEF.md
# Shared Synchronization Register File

This block is a small register file that hardware threads share for fast coordination. A thread can request an indivisible add or subtract on one register. The result goes to a chosen destination register. The operands are a source shared register and a second value, which the issuing logic supplies from a local register or from a constant. A thread can also ask to sleep until a named shared register holds a given value. Such a request is parked in a waiter table instead of spinning in the execution core. The parked thread keeps its program counter and its register segment in the surrounding logic while it waits.

On every cycle the waiter table compares each parked entry against the register values that result from that cycle's update. When an entry's condition is true, the block wakes that thread by pulsing a release strobe that carries the thread identifier. A barrier is built from these two operations. Each participant adds one to a counter register, then blocks until the counter equals the number of participants. A read port lets the surrounding logic, or a test, observe any register.

Top module: `shreg_sync_top`

## Requirements
- R1: While and after reset every shared register reads zero, the waiter table is empty, and `rel_valid` and `blk_retry` are low.
- R2: With `upd_valid` high and `upd_sub` low, register `upd_dst` takes the value of register `upd_src` plus `upd_opnd`, modulo 2^DW. `rd_data` shows the new value from the cycle after the clock edge.
- R3: With `upd_valid` high and `upd_sub` high, register `upd_dst` takes the value of register `upd_src` minus `upd_opnd`, wrapping modulo 2^DW.
- R4: `rd_data` shows, in the same cycle and without a clock edge, the stored value of the register selected by `rd_idx`. A pending update is not yet visible.
- R5: A block request whose condition already holds raises `rel_valid`, with `rel_tid` equal to its thread identifier, in the next cycle. The request never enters the table and never causes a retry, even when the table is full.
- R6: When an update and a block request arrive in the same cycle, the block condition is judged against the value the update produces.
- R7: A parked waiter is released in the cycle after the clock edge at which its register holds the target value. It is judged against each cycle's post-update register value and leaves the table when released.
- R8: At most one release occurs per cycle. An immediately satisfied new request wins. Otherwise the satisfied waiter in the lowest-numbered slot is released, and the other satisfied waiters stay parked for later cycles.
- R9: A block request that is not immediately satisfied, arriving while all slots are occupied, raises `blk_retry` in the same cycle and is discarded. That thread is never released.
- R10: An accepted block request occupies the lowest-numbered free slot. With slots filled in sequence, equally satisfied waiters are released in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | Atomic update request this cycle |
| upd_sub | input | 1 | 0 = add, 1 = subtract |
| upd_dst | input | $clog2(NREG) | Destination shared register |
| upd_src | input | $clog2(NREG) | Source shared register |
| upd_opnd | input | DW | Second operand (local register value or constant) |
| blk_valid | input | 1 | Block request this cycle |
| blk_tid | input | TIDW | Thread identifier of the blocking thread |
| blk_idx | input | $clog2(NREG) | Shared register to watch |
| blk_target | input | DW | Value that wakes the thread |
| blk_retry | output | 1 | Block request refused, table full |
| rel_valid | output | 1 | Release strobe |
| rel_tid | output | TIDW | Thread identifier being released |
| rd_idx | input | $clog2(NREG) | Read port index |
| rd_data | output | DW | Read port data |

## Verification
The situation hardest to reach from the ports combines three conditions. Several parked waiters become satisfied by a single update. The table is still full when a further request arrives. A new, already satisfied request then lands in the middle of the drain. The stimulus fills every slot with threads waiting on one register for one value and offers one more request, which must be refused. It then offers an already true request while the table is full. Next it makes the watched register reach the target with one add and injects an immediately true request during the drain. This exposes the release order, the priority of immediate wakes and the loss of the refused thread. A long run with narrow value and index ranges then produces frequent collisions between updates, checks and releases. A behavioural model follows the run cycle by cycle.

// File: rtl/shreg_pkg.sv
// Shared types for the shared synchronization register file.
// Assumes nothing beyond IEEE 1800-2017 packages.
package shreg_pkg;

    // Kind of atomic update applied to a shared register.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } atom_op_e;

endpackage

// File: rtl/shreg_alu.sv
// Atomic arithmetic unit: produces the single result of an add or a
// subtract on a shared register value. Purely combinational; the
// caller decides where the result is written.
// Assumes the result wraps modulo 2^DW.
module shreg_alu #(
    parameter int DW = 16
) (
    input  logic              sub,
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    output logic [DW-1:0]     y
);
    import shreg_pkg::*;

    atom_op_e op;

    // Pick the operation from the request bit.
    always_comb op = sub ? OP_SUB : OP_ADD;

    // Compute the wrapped result.
    always_comb begin
        case (op)
            OP_SUB:  y = a - b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/shreg_waiters.sv
// Waiter table with release arbitration. Each slot parks a thread id,
// a register index and a target value. Every cycle each slot is compared
// with the post-update register values; one release per cycle is issued,
// an immediately satisfied new request first, then the lowest slot.
// Assumes NWAIT >= 2 and that the caller computes imm_hit from the same
// post-update values it passes in nxt_vals.
module shreg_waiters #(
    parameter int NREG  = 16,
    parameter int DW    = 16,
    parameter int TIDW  = 6,
    parameter int NWAIT = 4,
    localparam int IDXW = $clog2(NREG),
    localparam int SLW  = $clog2(NWAIT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREG-1:0][DW-1:0]   nxt_vals,
    input  logic                      blk_valid,
    input  logic                      imm_hit,
    input  logic [TIDW-1:0]           blk_tid,
    input  logic [IDXW-1:0]           blk_idx,
    input  logic [DW-1:0]             blk_target,
    output logic                      blk_retry,
    output logic                      rel_valid,
    output logic [TIDW-1:0]           rel_tid
);
    logic [NWAIT-1:0]             wv;
    logic [NWAIT-1:0][TIDW-1:0]   wtid;
    logic [NWAIT-1:0][IDXW-1:0]   widx;
    logic [NWAIT-1:0][DW-1:0]     wtgt;
    logic [NWAIT-1:0]             hit;
    logic                         hit_any;
    logic [SLW-1:0]               hit_sel;
    logic                         free_any;
    logic [SLW-1:0]               free_sel;
    logic                         imm_rel;
    logic                         slot_rel;
    logic                         store;

    // Per-slot match of the watched register against its target.
    for (genvar g = 0; g < NWAIT; g++) begin : g_match
        always_comb hit[g] = wv[g] && (nxt_vals[widx[g]] == wtgt[g]);
    end

    // Lowest satisfied slot.
    always_comb begin
        hit_any = 1'b0;
        hit_sel = '0;
        for (int i = NWAIT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                hit_any = 1'b1;
                hit_sel = SLW'(i);
            end
        end
    end

    // Lowest free slot.
    always_comb begin
        free_any = 1'b0;
        free_sel = '0;
        for (int i = NWAIT - 1; i >= 0; i--) begin
            if (!wv[i]) begin
                free_any = 1'b1;
                free_sel = SLW'(i);
            end
        end
    end

    // Release selection, storage and refusal decisions.
    always_comb begin
        imm_rel   = blk_valid && imm_hit;
        slot_rel  = hit_any && !imm_rel;
        store     = blk_valid && !imm_hit && free_any;
        blk_retry = blk_valid && !imm_hit && !free_any;
    end

    // Table state and the registered release strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wv        <= '0;
            wtid      <= '0;
            widx      <= '0;
            wtgt      <= '0;
            rel_valid <= 1'b0;
            rel_tid   <= '0;
        end else begin
            rel_valid <= imm_rel || slot_rel;
            if (imm_rel) begin
                rel_tid <= blk_tid;
            end else if (slot_rel) begin
                rel_tid      <= wtid[hit_sel];
                wv[hit_sel]  <= 1'b0;
            end
            if (store) begin
                wv[free_sel]   <= 1'b1;
                wtid[free_sel] <= blk_tid;
                widx[free_sel] <= blk_idx;
                wtgt[free_sel] <= blk_target;
            end
        end
    end

    // R5: an already true request is released next cycle with its own id.
    assert_imm_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        imm_rel |=> rel_valid && rel_tid == $past(blk_tid));

    // R8: a satisfied slot yields exactly one release and leaves the table.
    assert_one_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rel |=> rel_valid && rel_tid == $past(wtid[hit_sel])
                     && !wv[$past(hit_sel)]);

    // R9: a refused request never grows the table.
    assert_retry_no_growth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_retry |=> $countones(wv) <= $past($countones(wv)));

    // R10: an accepted request adds exactly one occupied slot.
    assert_store_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> wv[$past(free_sel)] && $countones(wv) ==
                  $past($countones(wv)) + 1 - ($past(slot_rel) ? 1 : 0));
endmodule

// File: rtl/shreg_sync_top.sv
// Shared synchronization register file: NREG shared registers with one
// atomic add/subtract port, a combinational read port and a waiter table
// that wakes blocked threads on value equality.
// Assumes NREG is a power of two between 8 and 16 and at most one update
// and one block request per cycle.
module shreg_sync_top #(
    parameter int NREG  = 16,
    parameter int DW    = 16,
    parameter int TIDW  = 6,
    parameter int NWAIT = 4,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic              upd_sub,
    input  logic [IDXW-1:0]   upd_dst,
    input  logic [IDXW-1:0]   upd_src,
    input  logic [DW-1:0]     upd_opnd,
    input  logic              blk_valid,
    input  logic [TIDW-1:0]   blk_tid,
    input  logic [IDXW-1:0]   blk_idx,
    input  logic [DW-1:0]     blk_target,
    output logic              blk_retry,
    output logic              rel_valid,
    output logic [TIDW-1:0]   rel_tid,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [DW-1:0]     rd_data
);
    logic [NREG-1:0][DW-1:0]  regs;
    logic [NREG-1:0][DW-1:0]  nxt_vals;
    logic [DW-1:0]            alu_y;
    logic                     imm_hit;

    shreg_alu #(.DW(DW)) alu_i (
        .sub (upd_sub),
        .a   (regs[upd_src]),
        .b   (upd_opnd),
        .y   (alu_y)
    );

    // Post-update view of every register.
    for (genvar g = 0; g < NREG; g++) begin : g_next
        always_comb nxt_vals[g] = (upd_valid && upd_dst == IDXW'(g)) ? alu_y : regs[g];
    end

    // Commit the post-update values.
    always_ff @(posedge clk) begin
        if (!rst_n) regs <= '0;
        else        regs <= nxt_vals;
    end

    // Immediate satisfaction test for the incoming block request.
    always_comb imm_hit = (nxt_vals[blk_idx] == blk_target);

    // Read port.
    always_comb rd_data = regs[rd_idx];

    shreg_waiters #(
        .NREG(NREG), .DW(DW), .TIDW(TIDW), .NWAIT(NWAIT)
    ) waiters_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_vals   (nxt_vals),
        .blk_valid  (blk_valid),
        .imm_hit    (imm_hit),
        .blk_tid    (blk_tid),
        .blk_idx    (blk_idx),
        .blk_target (blk_target),
        .blk_retry  (blk_retry),
        .rel_valid  (rel_valid),
        .rel_tid    (rel_tid)
    );

    // R2: an add lands in the destination on the next cycle.
    assert_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !upd_sub |=>
            regs[$past(upd_dst)] == DW'($past(regs[upd_src]) + $past(upd_opnd)));

    // R3: a subtract lands in the destination on the next cycle.
    assert_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_sub |=>
            regs[$past(upd_dst)] == DW'($past(regs[upd_src]) - $past(upd_opnd)));
endmodule

// File: tb/shreg_sync_top_tb.sv
// Bench for the shared synchronization register file: a behavioural
// model is advanced on every cycle and compared with the ports.
module shreg_sync_top_tb_top;
    localparam int NREG = 16;
    localparam int DW = 16;
    localparam int TIDW = 6;
    localparam int NWAIT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_valid = 1'b0, upd_sub = 1'b0;
    logic [3:0] upd_dst = '0, upd_src = '0, blk_idx = '0, rd_idx = '0;
    logic [15:0] upd_opnd = '0, blk_target = '0;
    logic blk_valid = 1'b0;
    logic [5:0] blk_tid = '0;
    logic blk_retry, rel_valid;
    logic [5:0] rel_tid;
    logic [15:0] rd_data;

    int errors = 0;
    int checks = 0;

    logic [15:0] m_reg [NREG];
    bit          m_wv  [NWAIT];
    logic [5:0]  m_tid [NWAIT];
    logic [3:0]  m_idx [NWAIT];
    logic [15:0] m_tgt [NWAIT];

    always #4 clk = ~clk;

    shreg_sync_top #(.NREG(NREG), .DW(DW), .TIDW(TIDW), .NWAIT(NWAIT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_sub(upd_sub), .upd_dst(upd_dst),
        .upd_src(upd_src), .upd_opnd(upd_opnd),
        .blk_valid(blk_valid), .blk_tid(blk_tid), .blk_idx(blk_idx),
        .blk_target(blk_target), .blk_retry(blk_retry),
        .rel_valid(rel_valid), .rel_tid(rel_tid),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // One cycle: drive, check combinational outputs, advance model, check release.
    task automatic step(input logic uv, input logic us, input logic [3:0] ud,
                        input logic [3:0] usrc, input logic [15:0] uop,
                        input logic bv, input logic [5:0] bt, input logic [3:0] bi,
                        input logic [15:0] bg, input logic [3:0] ri, input string tag);
        logic [15:0] nx [NREG];
        logic imm, full, exp_rv, done;
        logic [5:0] exp_rt;
        int fs;
        upd_valid = uv; upd_sub = us; upd_dst = ud; upd_src = usrc; upd_opnd = uop;
        blk_valid = bv; blk_tid = bt; blk_idx = bi; blk_target = bg; rd_idx = ri;
        #1;
        for (int i = 0; i < NREG; i++) nx[i] = m_reg[i];
        if (uv) nx[ud] = us ? m_reg[usrc] - uop : m_reg[usrc] + uop;
        imm = bv && (nx[bi] == bg);
        full = 1'b1;
        fs = -1;
        for (int i = NWAIT - 1; i >= 0; i--) if (!m_wv[i]) begin full = 1'b0; fs = i; end
        check(blk_retry, bv && !imm && full, {"R9 retry ", tag});
        check(rd_data, m_reg[ri], {"R4 read ", tag});
        exp_rv = 1'b0; exp_rt = '0;
        if (imm) begin
            exp_rv = 1'b1; exp_rt = bt;
        end else begin
            done = 1'b0;
            for (int i = 0; i < NWAIT; i++) begin
                if (!done && m_wv[i] && nx[m_idx[i]] == m_tgt[i]) begin
                    done = 1'b1; exp_rv = 1'b1; exp_rt = m_tid[i]; m_wv[i] = 1'b0;
                end
            end
        end
        if (bv && !imm && !full) begin
            m_wv[fs] = 1'b1; m_tid[fs] = bt; m_idx[fs] = bi; m_tgt[fs] = bg;
        end
        for (int i = 0; i < NREG; i++) m_reg[i] = nx[i];
        @(posedge clk);
        @(negedge clk);
        check(rel_valid, exp_rv, {"R8 rel_valid ", tag});
        if (exp_rv) check(rel_tid, exp_rt, {"R8 rel_tid ", tag});
    endtask

    task automatic idle(input logic [3:0] ri, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, ri, tag);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) m_reg[i] = '0;
        for (int i = 0; i < NWAIT; i++) begin
            m_wv[i] = 1'b0; m_tid[i] = '0; m_idx[i] = '0; m_tgt[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state, observed during reset.
        check(rel_valid, 0, "R1 rel_valid in reset");
        check(blk_retry, 0, "R1 retry in reset");
        for (int i = 0; i < NREG; i++) begin
            rd_idx = 4'(i); #1;
            check(rd_data, 0, "R1 register zero");
        end
        rst_n = 1'b1;
        idle(0, "R1");

        // R2 and R3: add, then subtract with wrap.
        step(1, 0, 1, 0, 16'd5, 0, 0, 0, 0, 1, "R2");
        idle(1, "R2");
        step(1, 1, 2, 1, 16'd7, 0, 0, 0, 0, 2, "R3");
        idle(2, "R3");
        check(rd_data, 16'hFFFE, "R3 wrap value");

        // R5: condition already true.
        step(0, 0, 0, 0, 0, 1, 6'd9, 1, 16'd5, 1, "R5");
        // R6: same-cycle update and block.
        step(1, 0, 3, 3, 16'd1, 1, 6'd10, 3, 16'd1, 3, "R6");
        idle(3, "R6");

        // R7 and R8: barrier of three on register 4.
        step(0, 0, 0, 0, 0, 1, 6'd1, 4, 16'd3, 4, "R7");
        step(1, 0, 4, 4, 16'd1, 1, 6'd2, 4, 16'd3, 4, "R7");
        step(1, 0, 4, 4, 16'd1, 1, 6'd3, 4, 16'd3, 4, "R7");
        step(1, 0, 4, 4, 16'd1, 0, 0, 0, 0, 4, "R7");
        idle(4, "R8");
        idle(4, "R8");
        idle(4, "R8");

        // R10 and R9: fill the table, refuse the next, accept an immediate.
        for (int t = 20; t < 24; t++) step(0, 0, 0, 0, 0, 1, 6'(t), 5, 16'd100, 5, "R10");
        step(0, 0, 0, 0, 0, 1, 6'd24, 5, 16'd100, 5, "R9");
        step(0, 0, 0, 0, 0, 1, 6'd25, 5, 16'd0, 5, "R5");
        step(1, 0, 5, 5, 16'd100, 0, 0, 0, 0, 5, "R8");
        step(0, 0, 0, 0, 0, 1, 6'd30, 5, 16'd100, 5, "R8");
        for (int k = 0; k < 5; k++) idle(5, "R9");

        // Mixed traffic with narrow ranges for frequent collisions.
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 1), $urandom_range(0, 1), 4'($urandom_range(0, 3)),
                 4'($urandom_range(0, 3)), 16'($urandom_range(0, 1)),
                 $urandom_range(0, 1), 6'($urandom_range(0, 63)),
                 4'($urandom_range(0, 3)), 16'($urandom_range(0, 3)),
                 4'($urandom_range(0, 3)), "R7");
        end
        for (int k = 0; k < 8; k++) idle(0, "R8");
        summary();
        $finish;
    end
endmodule